// File: doc/BRIEF.md
# Pointer-register addressing unit

This block turns one 16-bit instruction word of an 8-bit core into the address of a memory access made through one of the core's 16-bit pointer pairs, together with the new pointer value when the instruction changes it. It handles data-memory loads and stores through the X, Y and Z pointers. These can be plain, post-increment, pre-decrement, or take a 6-bit unsigned displacement on Y or Z. It also handles program-memory loads through Z, with optional Z increment, and the extended program-memory load. That load places an extra high-byte register above Z to form a 24-bit address and, when it increments, writes both the byte and Z back.

The same unit performs add-immediate and subtract-immediate on a register word for the four upper register pairs. It returns the 16-bit result with carry, zero and negative flags. The core presents the upper eight registers and the extra high byte alongside the opcode. One cycle later the unit returns a registered access request, the writeback for the pointer and the high byte, the flag update and the number of extra cycles the instruction costs. The memories themselves are outside the block.

Top module: `ptr_addr_unit`

## Requirements
- R1: `pair_bytes` byte k (bits 8k+7:8k) holds register 24+k, and pair p (0..3) is the word with low byte 24+2p and high byte 25+2p. X is pair 1, Y pair 2, Z pair 3. A plain X access (low nibble 1100) uses that word as `acc_addr` with bits 23:16 zero, sets `extra_cyc`=1 and makes no writeback.
- R2: Post-increment (opcode bits 1:0 = 01) issues the access at the pointer value and writes pointer+1 modulo 2^16 to `ptr_idx`, so 0xFFFF becomes 0x0000.
- R3: Pre-decrement (opcode bits 1:0 = 10) issues the access at pointer-1 modulo 2^16 and writes that same value back.
- R4: Opcodes of the form 1001 00sd dddd nnnn pick the pointer from the low nibble: 1100/1101/1110 give X, 1001/1010 give Y, 0001/0010 give Z. Bit 9 (s) set marks a store and clear marks a load.
- R5: The form 10q0 qqsd dddd yqqq adds the 6-bit unsigned offset {bit13, bits11:10, bits2:0} to Y when bit 3 is 1, or to Z when it is 0. Bit 9 marks a store, the pointer is not written, and `extra_cyc`=1.
- R6: Program loads 0x95C8 and 1001 000d dddd 010i read at Z with `acc_prog`=1, bits 23:16 zero and `extra_cyc`=2. With i=1, Z+1 is written back to pair 3.
- R7: Extended program loads 0x95D8 and 1001 000d dddd 011i read at {ext_hi, Z}. With i=1 the 24-bit sum plus one is written back: bits 15:0 to Z and bits 23:16 through `ext_we`/`ext_wdata`.
- R8: Word operations 1001 011u KKpp KKKK (u=1 subtract) combine the 6-bit constant K with pair pp modulo 2^16. The result is written to `ptr_idx`=pp with `flag_we`=1, `acc_valid`=0 and `extra_cyc`=1.
- R9: For word operations, `flag_c` is the carry out of bit 15 on add or the borrow on subtract, `flag_z` is set when the result is zero and `flag_n` is result bit 15.
- R10: Results appear one clock after `in_valid` is sampled high and last one cycle. An opcode outside the forms above, or a cycle with `in_valid` low, produces no access, no writeback and no flag update.
- R11: While `rst_n` is low every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Opcode valid this cycle |
| opcode | input | 16 | Instruction word |
| pair_bytes | input | 64 | Registers 24..31, byte k = register 24+k |
| ext_hi | input | 8 | Extra high byte for extended program addressing |
| acc_valid | output | 1 | Memory access requested |
| acc_store | output | 1 | Access is a data store |
| acc_prog | output | 1 | Access targets program memory |
| acc_addr | output | 24 | Effective address |
| extra_cyc | output | 2 | Extra cycles the instruction costs |
| ptr_we | output | 1 | Pointer/pair writeback enable |
| ptr_idx | output | 2 | Pair written (0..3) |
| ptr_wdata | output | 16 | New pair value |
| ext_we | output | 1 | High-byte writeback enable |
| ext_wdata | output | 8 | New high byte |
| flag_we | output | 1 | Flag update enable |
| flag_c | output | 1 | Carry/borrow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |

## Verification
Each pointer is loaded with a distinct value, so a wrong pair selection shows up in the address. Post-increment is run at 0xFFFF and pre-decrement at 0x0000, which separates modulo wrap from a carry leaking into the upper address byte. Displacement uses the largest offset on Y and a small offset with a store on Z. This tells the offset bit order and the Y/Z select apart. The extended increment is run at Z=0xFFFF to prove the carry reaches the high byte. The word operations are driven to an overflow, an exact zero and a negative borrow, and an unknown opcode and an idle cycle confirm nothing is written.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  localparam int OFFS_W = 6;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    K_NONE, K_DATA, K_DISP, K_PROG, K_WORD
  } kind_e;

  typedef enum logic [1:0] {
    M_PLAIN, M_POSTINC, M_PREDEC
  } mode_e;

  typedef struct packed {
    kind_e              kind;
    mode_e              mode;
    logic               store;
    logic               ext;
    logic               sub;
    logic [SEL_W-1:0]   pair;
    logic [OFFS_W-1:0]  offs;
  } dec_t;
endpackage

// File: rtl/ptr_op_decode.sv
module ptr_op_decode
  import ptr_addr_pkg::*;
(
  input  logic [15:0] opcode,
  output dec_t        dec
);
  localparam logic [1:0] PX = 2'd1;
  localparam logic [1:0] PY = 2'd2;
  localparam logic [1:0] PZ = 2'd3;

  always_comb begin
    dec      = '0;
    dec.kind = K_NONE;
    dec.mode = M_PLAIN;
    if ((opcode & 16'hD000) == 16'h8000) begin
      dec.kind  = K_DISP;
      dec.pair  = opcode[3] ? PY : PZ;
      dec.offs  = {opcode[13], opcode[11:10], opcode[2:0]};
      dec.store = opcode[9];
    end else if (opcode[15:10] == 6'b100100) begin
      dec.store = opcode[9];
      case (opcode[3:0])
        4'hC: begin dec.kind = K_DATA; dec.pair = PX; dec.mode = M_PLAIN;   end
        4'hD: begin dec.kind = K_DATA; dec.pair = PX; dec.mode = M_POSTINC; end
        4'hE: begin dec.kind = K_DATA; dec.pair = PX; dec.mode = M_PREDEC;  end
        4'h9: begin dec.kind = K_DATA; dec.pair = PY; dec.mode = M_POSTINC; end
        4'hA: begin dec.kind = K_DATA; dec.pair = PY; dec.mode = M_PREDEC;  end
        4'h1: begin dec.kind = K_DATA; dec.pair = PZ; dec.mode = M_POSTINC; end
        4'h2: begin dec.kind = K_DATA; dec.pair = PZ; dec.mode = M_PREDEC;  end
        4'h4, 4'h5, 4'h6, 4'h7: begin
          if (!opcode[9]) begin
            dec.kind  = K_PROG;
            dec.pair  = PZ;
            dec.ext   = opcode[1];
            dec.mode  = opcode[0] ? M_POSTINC : M_PLAIN;
            dec.store = 1'b0;
          end else begin
            dec.store = 1'b0;
          end
        end
        default: dec.store = 1'b0;
      endcase
    end else if (opcode == 16'h95C8 || opcode == 16'h95D8) begin
      dec.kind = K_PROG;
      dec.pair = PZ;
      dec.ext  = opcode[4];
    end else if (opcode[15:9] == 7'b1001011) begin
      dec.kind = K_WORD;
      dec.sub  = opcode[8];
      dec.pair = opcode[5:4];
      dec.offs = {opcode[7:6], opcode[3:0]};
    end
  end
endmodule

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
  import ptr_addr_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int EXT_W = 8,
  localparam int ADDR_W = PTR_W + EXT_W
) (
  input  dec_t              dec,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [EXT_W-1:0]  ext_hi,
  output logic [ADDR_W-1:0] addr,
  output logic              wb_en,
  output logic [PTR_W-1:0]  wb_data,
  output logic              ext_en,
  output logic [EXT_W-1:0]  ext_data
);
  logic [PTR_W-1:0]  ptr_inc, ptr_dec, ptr_off;
  logic [ADDR_W-1:0] long_ptr, long_inc;

  assign ptr_inc  = ptr + PTR_W'(1);
  assign ptr_dec  = ptr - PTR_W'(1);
  assign ptr_off  = ptr + PTR_W'(dec.offs);
  assign long_ptr = {ext_hi, ptr};
  assign long_inc = long_ptr + ADDR_W'(1);

  always_comb begin
    addr     = '0;
    wb_en    = 1'b0;
    wb_data  = '0;
    ext_en   = 1'b0;
    ext_data = '0;
    case (dec.kind)
      K_DATA: begin
        addr    = {{EXT_W{1'b0}}, (dec.mode == M_PREDEC) ? ptr_dec : ptr};
        wb_en   = (dec.mode != M_PLAIN);
        wb_data = (dec.mode == M_PREDEC) ? ptr_dec : ptr_inc;
      end
      K_DISP: addr = {{EXT_W{1'b0}}, ptr_off};
      K_PROG: begin
        addr  = dec.ext ? long_ptr : {{EXT_W{1'b0}}, ptr};
        wb_en = (dec.mode == M_POSTINC);
        if (dec.ext) begin
          wb_data  = long_inc[PTR_W-1:0];
          ext_en   = (dec.mode == M_POSTINC);
          ext_data = long_inc[ADDR_W-1:PTR_W];
        end else begin
          wb_data  = ptr_inc;
        end
      end
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/ptr_word_alu.sv
module ptr_word_alu #(
  parameter int PTR_W = 16,
  parameter int IMM_W = 6
) (
  input  logic [PTR_W-1:0] val,
  input  logic [IMM_W-1:0] imm,
  input  logic             sub,
  output logic [PTR_W-1:0] res,
  output logic             c,
  output logic             z,
  output logic             n
);
  logic [PTR_W:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, val} - (PTR_W+1)'(imm);
    else     wide = {1'b0, val} + (PTR_W+1)'(imm);
    res = wide[PTR_W-1:0];
    c   = wide[PTR_W];
    z   = (wide[PTR_W-1:0] == '0);
    n   = wide[PTR_W-1];
  end
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import ptr_addr_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int EXT_W = 8,
  parameter int NPAIR = 4,
  localparam int ADDR_W = PTR_W + EXT_W,
  localparam int BUS_W  = NPAIR * PTR_W,
  localparam int IDX_W  = $clog2(NPAIR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       opcode,
  input  logic [BUS_W-1:0]  pair_bytes,
  input  logic [EXT_W-1:0]  ext_hi,
  output logic              acc_valid,
  output logic              acc_store,
  output logic              acc_prog,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        extra_cyc,
  output logic              ptr_we,
  output logic [IDX_W-1:0]  ptr_idx,
  output logic [PTR_W-1:0]  ptr_wdata,
  output logic              ext_we,
  output logic [EXT_W-1:0]  ext_wdata,
  output logic              flag_we,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_n
);
  dec_t             dec;
  logic [PTR_W-1:0] pair_w [NPAIR];
  logic [PTR_W-1:0] sel_ptr;

  ptr_op_decode u_dec (.opcode(opcode), .dec(dec));

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    // low register plus high register shifted up one byte
    assign pair_w[g] = PTR_W'(pair_bytes[g*PTR_W +: 8])
                     | (PTR_W'(pair_bytes[g*PTR_W+8 +: PTR_W-8]) << 8);
  end

  assign sel_ptr = pair_w[IDX_W'(dec.pair)];

  logic [ADDR_W-1:0] c_addr;
  logic              c_wb, c_ext_en;
  logic [PTR_W-1:0]  c_wdata;
  logic [EXT_W-1:0]  c_ext;

  ptr_addr_calc #(.PTR_W(PTR_W), .EXT_W(EXT_W)) u_calc (
    .dec(dec), .ptr(sel_ptr), .ext_hi(ext_hi), .addr(c_addr),
    .wb_en(c_wb), .wb_data(c_wdata), .ext_en(c_ext_en), .ext_data(c_ext)
  );

  logic [PTR_W-1:0] w_res;
  logic             w_c, w_z, w_n;

  ptr_word_alu #(.PTR_W(PTR_W), .IMM_W(OFFS_W)) u_alu (
    .val(sel_ptr), .imm(dec.offs), .sub(dec.sub),
    .res(w_res), .c(w_c), .z(w_z), .n(w_n)
  );

  logic              acc_valid_d, acc_store_d, acc_prog_d;
  logic [ADDR_W-1:0] acc_addr_d;
  logic [1:0]        extra_cyc_d;
  logic              ptr_we_d, ext_we_d, flag_we_d, flag_c_d, flag_z_d, flag_n_d;
  logic [IDX_W-1:0]  ptr_idx_d;
  logic [PTR_W-1:0]  ptr_wdata_d;
  logic [EXT_W-1:0]  ext_wdata_d;

  always_comb begin
    acc_valid_d = 1'b0; acc_store_d = 1'b0; acc_prog_d = 1'b0;
    acc_addr_d  = '0;   extra_cyc_d = 2'd0;
    ptr_we_d    = 1'b0; ptr_idx_d   = '0;   ptr_wdata_d = '0;
    ext_we_d    = 1'b0; ext_wdata_d = '0;
    flag_we_d   = 1'b0; flag_c_d    = 1'b0; flag_z_d = 1'b0; flag_n_d = 1'b0;
    if (in_valid) begin
      case (dec.kind)
        K_DATA, K_DISP, K_PROG: begin
          acc_valid_d = 1'b1;
          acc_store_d = dec.store;
          acc_prog_d  = (dec.kind == K_PROG);
          acc_addr_d  = c_addr;
          extra_cyc_d = (dec.kind == K_PROG) ? 2'd2 : 2'd1;
          ptr_we_d    = c_wb;
          ptr_idx_d   = IDX_W'(dec.pair);
          ptr_wdata_d = c_wdata;
          ext_we_d    = c_ext_en;
          ext_wdata_d = c_ext;
        end
        K_WORD: begin
          extra_cyc_d = 2'd1;
          ptr_we_d    = 1'b1;
          ptr_idx_d   = IDX_W'(dec.pair);
          ptr_wdata_d = w_res;
          flag_we_d   = 1'b1;
          flag_c_d    = w_c;
          flag_z_d    = w_z;
          flag_n_d    = w_n;
        end
        default: acc_valid_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0; acc_store <= 1'b0; acc_prog <= 1'b0;
      acc_addr  <= '0;   extra_cyc <= 2'd0;
      ptr_we    <= 1'b0; ptr_idx   <= '0;   ptr_wdata <= '0;
      ext_we    <= 1'b0; ext_wdata <= '0;
      flag_we   <= 1'b0; flag_c    <= 1'b0; flag_z <= 1'b0; flag_n <= 1'b0;
    end else begin
      acc_valid <= acc_valid_d; acc_store <= acc_store_d; acc_prog <= acc_prog_d;
      acc_addr  <= acc_addr_d;  extra_cyc <= extra_cyc_d;
      ptr_we    <= ptr_we_d;    ptr_idx   <= ptr_idx_d;   ptr_wdata <= ptr_wdata_d;
      ext_we    <= ext_we_d;    ext_wdata <= ext_wdata_d;
      flag_we   <= flag_we_d;   flag_c    <= flag_c_d;
      flag_z    <= flag_z_d;    flag_n    <= flag_n_d;
    end
  end

  // data accesses never reach above the 16-bit space
  p_data_addr_16b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_prog) |-> (acc_addr[ADDR_W-1:PTR_W] == '0));

  // any pointer update issued with an access moves it by at most one step
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ptr_we && !ext_we) |->
      (ptr_wdata == acc_addr[PTR_W-1:0] || ptr_wdata == acc_addr[PTR_W-1:0] + PTR_W'(1)));

  // program memory is only read
  p_prog_no_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_prog |-> !acc_store);

  // high-byte writeback comes with the Z write and equals the address plus one
  p_ext_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (ptr_we && acc_prog && ({ext_wdata, ptr_wdata} == acc_addr + ADDR_W'(1))));

  // flag updates belong only to word operations, which issue no access
  p_flags_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (!acc_valid && ptr_we));

  // nothing appears unless an opcode was offered the cycle before
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!acc_valid && !ptr_we && !flag_we && !ext_we));
endmodule

// File: tb/ptr_addr_unit_tb_top.sv
module ptr_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] opcode;
  logic [63:0] pair_bytes;
  logic [7:0]  ext_hi;
  logic        acc_valid, acc_store, acc_prog, ptr_we, ext_we;
  logic        flag_we, flag_c, flag_z, flag_n;
  logic [23:0] acc_addr;
  logic [1:0]  extra_cyc, ptr_idx;
  logic [15:0] ptr_wdata;
  logic [7:0]  ext_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ptr_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .pair_bytes(pair_bytes), .ext_hi(ext_hi),
    .acc_valid(acc_valid), .acc_store(acc_store), .acc_prog(acc_prog),
    .acc_addr(acc_addr), .extra_cyc(extra_cyc), .ptr_we(ptr_we),
    .ptr_idx(ptr_idx), .ptr_wdata(ptr_wdata), .ext_we(ext_we),
    .ext_wdata(ext_wdata), .flag_we(flag_we), .flag_c(flag_c),
    .flag_z(flag_z), .flag_n(flag_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_pair(input int p, input logic [15:0] v);
    pair_bytes[p*16 +: 8]   = v[7:0];
    pair_bytes[p*16+8 +: 8] = v[15:8];
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic issue(input logic [15:0] op, input logic v);
    @(negedge clk);
    opcode   = op;
    in_valid = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_access(input string req, input logic st, input logic pg,
                            input logic [23:0] a, input logic [1:0] ex);
    chk(req, "acc_valid", 64'(acc_valid), 64'(1));
    chk(req, "acc_store", 64'(acc_store), 64'(st));
    chk(req, "acc_prog",  64'(acc_prog),  64'(pg));
    chk(req, "acc_addr",  64'(acc_addr),  64'(a));
    chk(req, "extra_cyc", 64'(extra_cyc), 64'(ex));
  endtask

  task automatic chk_wb(input string req, input logic we, input logic [1:0] idx,
                        input logic [15:0] d);
    chk(req, "ptr_we", 64'(ptr_we), 64'(we));
    if (we) begin
      chk(req, "ptr_idx",   64'(ptr_idx),   64'(idx));
      chk(req, "ptr_wdata", 64'(ptr_wdata), 64'(d));
    end
  endtask

  task automatic t_reset;
    chk("R11", "outputs in reset",
        {acc_valid, acc_store, acc_prog, ptr_we, ext_we, flag_we, flag_c, flag_z, flag_n,
         acc_addr, extra_cyc, ptr_idx, ptr_wdata[7:0]}, 64'd0);
  endtask

  task automatic t_plain_x;
    set_pair(1, 16'h1234);
    issue(16'h900C, 1'b1);
    chk_access("R1", 1'b0, 1'b0, 24'h001234, 2'd1);
    chk_wb("R1", 1'b0, 2'd0, 16'h0);
    issue(16'h920C, 1'b1);
    chk_access("R4", 1'b1, 1'b0, 24'h001234, 2'd1);
  endtask

  task automatic t_postinc;
    set_pair(1, 16'hFFFF);
    issue(16'h900D, 1'b1);
    chk_access("R2", 1'b0, 1'b0, 24'h00FFFF, 2'd1);
    chk_wb("R2", 1'b1, 2'd1, 16'h0000);
    set_pair(2, 16'h0200);
    issue(16'h9209, 1'b1);
    chk_access("R4", 1'b1, 1'b0, 24'h000200, 2'd1);
    chk_wb("R2", 1'b1, 2'd2, 16'h0201);
  endtask

  task automatic t_predec;
    set_pair(1, 16'h0000);
    issue(16'h900E, 1'b1);
    chk_access("R3", 1'b0, 1'b0, 24'h00FFFF, 2'd1);
    chk_wb("R3", 1'b1, 2'd1, 16'hFFFF);
    set_pair(3, 16'h0300);
    issue(16'h9002, 1'b1);
    chk_access("R4", 1'b0, 1'b0, 24'h0002FF, 2'd1);
    chk_wb("R3", 1'b1, 2'd3, 16'h02FF);
  endtask

  task automatic t_disp;
    set_pair(2, 16'h0200);
    set_pair(3, 16'h0300);
    issue(16'hAC0F, 1'b1);
    chk_access("R5", 1'b0, 1'b0, 24'h00023F, 2'd1);
    chk_wb("R5", 1'b0, 2'd0, 16'h0);
    issue(16'h8205, 1'b1);
    chk_access("R5", 1'b1, 1'b0, 24'h000305, 2'd1);
    chk_wb("R5", 1'b0, 2'd0, 16'h0);
  endtask

  task automatic t_prog;
    ext_hi = 8'h01;
    set_pair(3, 16'h0300);
    issue(16'h95C8, 1'b1);
    chk_access("R6", 1'b0, 1'b1, 24'h000300, 2'd2);
    chk_wb("R6", 1'b0, 2'd0, 16'h0);
    set_pair(3, 16'hFFFF);
    issue(16'h9005, 1'b1);
    chk_access("R6", 1'b0, 1'b1, 24'h00FFFF, 2'd2);
    chk_wb("R6", 1'b1, 2'd3, 16'h0000);
    chk("R6", "ext_we", 64'(ext_we), 64'(0));
  endtask

  task automatic t_ext;
    ext_hi = 8'h01;
    set_pair(3, 16'hFFFF);
    issue(16'h9007, 1'b1);
    chk_access("R7", 1'b0, 1'b1, 24'h01FFFF, 2'd2);
    chk_wb("R7", 1'b1, 2'd3, 16'h0000);
    chk("R7", "ext_we",    64'(ext_we),    64'(1));
    chk("R7", "ext_wdata", 64'(ext_wdata), 64'(8'h02));
    issue(16'h95D8, 1'b1);
    chk_access("R7", 1'b0, 1'b1, 24'h01FFFF, 2'd2);
    chk("R7", "no writeback", 64'({ptr_we, ext_we}), 64'(0));
  endtask

  task automatic t_word;
    set_pair(0, 16'hFFF0);
    issue(16'h96CF, 1'b1);
    chk("R8", "acc_valid", 64'(acc_valid), 64'(0));
    chk("R8", "extra_cyc", 64'(extra_cyc), 64'(1));
    chk_wb("R8", 1'b1, 2'd0, 16'h002F);
    chk("R9", "flags add ovf", 64'({flag_we, flag_c, flag_z, flag_n}), 64'(4'b1100));
    set_pair(3, 16'h0001);
    issue(16'h9731, 1'b1);
    chk_wb("R8", 1'b1, 2'd3, 16'h0000);
    chk("R9", "flags sub zero", 64'({flag_we, flag_c, flag_z, flag_n}), 64'(4'b1010));
    set_pair(1, 16'h0001);
    issue(16'h9712, 1'b1);
    chk_wb("R8", 1'b1, 2'd1, 16'hFFFF);
    chk("R9", "flags sub borrow", 64'({flag_we, flag_c, flag_z, flag_n}), 64'(4'b1101));
  endtask

  task automatic t_idle;
    issue(16'h0000, 1'b1);
    chk("R10", "unknown opcode",
        64'({acc_valid, ptr_we, ext_we, flag_we}), 64'(0));
    issue(16'h900D, 1'b0);
    chk("R10", "invalid cycle",
        64'({acc_valid, ptr_we, ext_we, flag_we}), 64'(0));
    issue(16'h900C, 1'b1);
    @(negedge clk);
    chk("R10", "single cycle pulse", 64'(acc_valid), 64'(0));
  endtask

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    opcode     = 16'h0;
    pair_bytes = 64'h0;
    ext_hi     = 8'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain_x();
    t_postinc();
    t_predec();
    t_disp();
    t_prog();
    t_ext();
    t_word();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule